// File: doc/BRIEF.md
# Programmable CPU Core Clock Divider Path

This block produces the CPU core clock from two incoming clock sources: a fast PLL clock and a slow crystal clock. A source mux picks which of the two feeds the divider stage. The divider offers three fixed taps (divide by 1, 2 and 3) and one programmable tap that divides by an even ratio 2×N. A final mux then sends either the divider result or the untouched crystal clock to the core. Software keeps the core on the crystal while the PLL settles, then switches the final mux back to the divider.

Two 32-bit control words are written and read over a small memory-mapped bus. The divisor word is at offset 0x00 and the control word is at offset 0x40. The clock-switching cells are modelled as synchronous selects inside one fabric clock domain. Each source clock arrives as a level that this fabric clock oversamples. The divider advances on the source rising edges it detects. To reach a ratio R, software uses the fixed tap R-1 when R is 3 or less. For a larger R it uses the programmable tap with N = floor(R/2).

Top module: `cpuclk_top`

## Requirements
- R1: After reset both control words read as zero. The core clock then follows the crystal clock, with the same period and the same high time.
- R2: A write at offset 0x00 or 0x40 stores all 32 bits, and the stored word reads back unchanged. Any other offset reads as zero, and a write to it changes neither control word.
- R3: When the tap select (control bits [3:2]) is 0, the core clock equals the selected source clock.
- R4: Tap select 1 divides by 2 with a 50% duty cycle.
- R5: Tap select 2 divides by 3. The output is high for one source period and low for two.
- R6: Tap select 3 divides by 2×N with a 50% duty cycle. N is the 9-bit field at bits [28:20] of the divisor word. An odd target ratio R is programmed as N = floor(R/2), so the output runs at ratio R-1.
- R7: Tap select 3 with N = 0 acts as divide by 1, so the clock keeps running.
- R8: Control bit 0 chooses the divider source: 1 selects the PLL and 0 selects the crystal.
- R9: Control bit 7 chooses the output: 0 passes the crystal clock straight through, and 1 passes the divider output.
- R10: The divisor bits outside [28:20] and the control bits other than 0, 2, 3 and 7 have no effect on the core clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that oversamples both sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lvl | input | 1 | Sampled level of the PLL clock |
| xtal_lvl | input | 1 | Sampled level of the crystal clock |
| reg_addr | input | 7 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| core_clk | output | 1 | Core clock level |

## Verification
A register write takes effect at the next clock edge, and read data follows the address in the same cycle. The bench therefore samples reads 1 ns after it changes the address on a falling edge.

The core clock passes through registers before it reaches the pin. In crystal pass-through it lags the crystal by one fabric cycle. Through the divider it lags the source by two fabric cycles. A change of tap or N restarts the divider count.

Because of these lags, each check compares a clock shape rather than sampling a single cycle. The shape is the period and the high time, counted in fabric cycles between two output rising edges. The monitor arms only after the new setting has had at least two output periods to settle.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int NW     = 9;

  // Register offsets
  localparam logic [ADDR_W-1:0] OFS_DIVN = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 7'h40;

  // Field positions
  localparam int N_LSB      = 20;
  localparam int TAP_LSB    = 2;
  localparam int BIT_SRCPLL = 0;
  localparam int BIT_OUTDIV = 7;

  typedef enum logic [1:0] {
    TAP_D1 = 2'd0,
    TAP_D2 = 2'd1,
    TAP_D3 = 2'd2,
    TAP_DN = 2'd3
  } tap_e;
endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs
  import cpuclk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int W  = NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [W-1:0]  n_val,
  output tap_e          tap,
  output logic          src_pll,
  output logic          out_div
);
  logic [DW-1:0] divn_q, divn_d;
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          divn_en, ctrl_en;

  always_comb begin
    divn_en = wr && (addr == AW'(OFS_DIVN));
    ctrl_en = wr && (addr == AW'(OFS_CTRL));
    divn_d  = divn_en ? wdata : divn_q;
    ctrl_d  = ctrl_en ? wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divn_q <= '0;
      ctrl_q <= '0;
    end else begin
      divn_q <= divn_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    if (addr == AW'(OFS_DIVN))      rdata = divn_q;
    else if (addr == AW'(OFS_CTRL)) rdata = ctrl_q;
    else                            rdata = '0;
  end

  assign n_val   = divn_q[N_LSB +: W];
  assign tap     = tap_e'(ctrl_q[TAP_LSB +: 2]);
  assign src_pll = ctrl_q[BIT_SRCPLL];
  assign out_div = ctrl_q[BIT_OUTDIV];
endmodule

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
  import cpuclk_pkg::*;
#(
  parameter int W = NW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_lvl,
  input  tap_e         tap,
  input  logic [W-1:0] n_val,
  output logic         src_rise,
  output logic         div_lvl
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic         src_q;
  logic [W-1:0] cnt_q, cnt_d;
  logic         lvl_q, lvl_d;
  tap_e         tap_q;
  logic [W-1:0] n_q;
  logic         bypass, cfg_chg;
  logic [W-1:0] half;

  assign src_rise = src_lvl & ~src_q;
  assign div_lvl  = lvl_q;

  always_comb begin
    bypass  = (tap == TAP_D1) || ((tap == TAP_DN) && (n_val == '0));
    cfg_chg = (tap != tap_q) || (n_val != n_q);
    half    = (tap == TAP_D2) ? ONE : n_val;
    cnt_d   = cnt_q;
    lvl_d   = lvl_q;
    if (bypass) begin
      cnt_d = '0;
      lvl_d = src_lvl;
    end else if (cfg_chg) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (src_rise) begin
      if (tap == TAP_D3) begin
        if (cnt_q >= TWO) begin
          cnt_d = '0;
          lvl_d = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
          lvl_d = 1'b0;
        end
      end else if (cnt_q >= half - ONE) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
      tap_q <= TAP_D1;
      n_q   <= '0;
    end else begin
      src_q <= src_lvl;
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
      tap_q <= tap;
      n_q   <= n_val;
    end
  end
endmodule

// File: rtl/cpuclk_top.sv
module cpuclk_top
  import cpuclk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int W  = NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pll_lvl,
  input  logic          xtal_lvl,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          core_clk
);
  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic [W-1:0] n_val;
  tap_e         tap;
  logic         src_pll, out_div;
  logic         src_lvl, src_rise, div_lvl;
  logic         out_d, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cpuclk_regs #(.AW(AW), .DW(DW), .W(W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata), .n_val(n_val), .tap(tap),
    .src_pll(src_pll), .out_div(out_div)
  );

  assign src_lvl = src_pll ? pll_lvl : xtal_lvl;

  cpuclk_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .src_lvl(src_lvl), .tap(tap),
    .n_val(n_val), .src_rise(src_rise), .div_lvl(div_lvl)
  );

  assign out_d = out_div ? div_lvl : xtal_lvl;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= 1'b0;
    else             out_q <= out_d;
  end
  assign core_clk = out_q;
endmodule

// File: rtl/cpuclk_chk.sv
module cpuclk_chk
  import cpuclk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int W  = NW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [W-1:0]  n_val,
  input tap_e          tap,
  input logic          out_div,
  input logic          xtal_lvl,
  input logic          src_lvl,
  input logic          src_rise,
  input logic          div_lvl,
  input logic          core_clk
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (n_val == '0 && tap == TAP_D1 && !out_div)
        else $error("control fields not cleared in reset");
    end
  end

  assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(OFS_CTRL)) |=>
      (reg_addr != AW'(OFS_CTRL) || reg_rdata == $past(reg_wdata)));

  assert_div3_one_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == TAP_D3 && $past(tap) == TAP_D3 && div_lvl && src_rise) |=> !div_lvl);

  assert_bypass_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == TAP_D1 || (tap == TAP_DN && n_val == '0)) |=> (div_lvl == $past(src_lvl)));

  assert_xtal_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_div |=> (core_clk == $past(xtal_lvl)));
endmodule

bind cpuclk_top cpuclk_chk #(.AW(AW), .DW(DW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .n_val(n_val), .tap(tap),
  .out_div(out_div), .xtal_lvl(xtal_lvl), .src_lvl(src_lvl),
  .src_rise(src_rise), .div_lvl(div_lvl), .core_clk(core_clk)
);

// File: tb/cpuclk_top_bench.sv
module cpuclk_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PLL_HALF   = 2;   // PLL period = 4 fabric cycles
  localparam int XTAL_HALF  = 5;   // crystal period = 10 fabric cycles
  localparam int WATCHDOG   = 150000;

  typedef struct {
    string tag;
    int    period;
    int    high;
  } shape_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        pll_lvl = 1'b0;
  logic        xtal_lvl = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_clk;

  int total = 0;
  int bad = 0;
  shape_t exp_q[$];
  bit armed = 1'b0;

  cpuclk_top u_cpuclk_top (
    .clk(clk), .rst_n(rst_n), .pll_lvl(pll_lvl), .xtal_lvl(xtal_lvl),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .core_clk(core_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Source clock generators, changed on falling edges
  int pll_cnt = 0;
  int xtal_cnt = 0;
  always @(negedge clk) begin
    if (pll_cnt == PLL_HALF - 1) begin pll_cnt <= 0; pll_lvl <= ~pll_lvl; end
    else pll_cnt <= pll_cnt + 1;
    if (xtal_cnt == XTAL_HALF - 1) begin xtal_cnt <= 0; xtal_lvl <= ~xtal_lvl; end
    else xtal_cnt <= xtal_cnt + 1;
  end

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Monitor: measures one output period after arming and compares
  int  mstate = 0;
  int  per = 0;
  int  hi = 0;
  bit  in_high = 1'b0;
  bit  prev = 1'b0;
  always @(negedge clk) begin
    case (mstate)
      0: if (armed) mstate <= 1;
      1: if (core_clk && !prev) begin
           per <= 1; hi <= 1; in_high <= 1'b1; mstate <= 2;
         end
      default: begin
        if (core_clk && !prev) begin
          shape_t e;
          e = exp_q.pop_front();
          check({e.tag, " period"}, per, e.period);
          check({e.tag, " high"}, hi, e.high);
          armed <= 1'b0;
          mstate <= 0;
        end else begin
          per <= per + 1;
          if (core_clk && in_high) hi <= hi + 1;
          if (!core_clk) in_high <= 1'b0;
        end
      end
    endcase
    prev <= core_clk;
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [6:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, reg_rdata, exp);
    end
  endtask

  // Driver: push expected shape after settling, wait for the monitor
  task automatic expect_shape(string tag, int period, int high);
    shape_t e;
    repeat (2 * period + 20) @(negedge clk);
    e.tag = tag; e.period = period; e.high = high;
    exp_q.push_back(e);
    armed = 1'b1;
    while (armed) @(negedge clk);
  endtask

  // Program a target ratio from the PLL
  task automatic set_ratio(int r, logic [31:0] ctrl_extra, logic [31:0] divn_extra);
    int sel;
    int n;
    if (r <= 3) begin sel = r - 1; n = 0; end
    else begin sel = 3; n = r / 2; end
    wr(7'h00, divn_extra | (32'(n) << 20));
    wr(7'h40, ctrl_extra | 32'h81 | (32'(sel) << 2));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd_check("R1 divisor word", 7'h00, 32'h0);
    rd_check("R1 control word", 7'h40, 32'h0);
    expect_shape("R1 crystal after reset", 2*XTAL_HALF, XTAL_HALF);

    // R2: register access
    wr(7'h00, 32'hA5A5_5A5A);
    rd_check("R2 divisor readback", 7'h00, 32'hA5A5_5A5A);
    wr(7'h40, 32'h1234_5670);
    rd_check("R2 control readback", 7'h40, 32'h1234_5670);
    wr(7'h20, 32'hFFFF_FFFF);
    rd_check("R2 unmapped reads zero", 7'h20, 32'h0);
    rd_check("R2 divisor untouched", 7'h00, 32'hA5A5_5A5A);
    rd_check("R2 control untouched", 7'h40, 32'h1234_5670);

    // R3 / R4 / R5 fixed taps from PLL
    set_ratio(1, 32'h0, 32'h0);
    expect_shape("R3 divide by 1", 2*PLL_HALF, PLL_HALF);
    set_ratio(2, 32'h0, 32'h0);
    expect_shape("R4 divide by 2", 4*PLL_HALF, 2*PLL_HALF);
    set_ratio(3, 32'h0, 32'h0);
    expect_shape("R5 divide by 3", 6*PLL_HALF, 2*PLL_HALF);

    // R6 programmable even taps
    set_ratio(4, 32'h0, 32'h0);
    expect_shape("R6 divide by 4", 8*PLL_HALF, 4*PLL_HALF);
    set_ratio(6, 32'h0, 32'h0);
    expect_shape("R6 divide by 6", 12*PLL_HALF, 6*PLL_HALF);
    set_ratio(7, 32'h0, 32'h0);
    expect_shape("R6 odd 7 rounds to 6", 12*PLL_HALF, 6*PLL_HALF);
    set_ratio(1022, 32'h0, 32'h0);
    expect_shape("R6 maximum N", 1022*2*PLL_HALF, 511*2*PLL_HALF);

    // R7: N = 0 with tap 3 is bypass
    wr(7'h00, 32'h0);
    wr(7'h40, 32'h8D);
    expect_shape("R7 N zero bypass", 2*PLL_HALF, PLL_HALF);

    // R8: crystal as divider source, divide by 2
    wr(7'h40, 32'h84);
    expect_shape("R8 crystal source div2", 4*XTAL_HALF, 2*XTAL_HALF);
    wr(7'h40, 32'h85);
    expect_shape("R8 PLL source div2", 4*PLL_HALF, 2*PLL_HALF);

    // R9: final mux to crystal ignores divider
    wr(7'h40, 32'h05);
    expect_shape("R9 crystal pass-through", 2*XTAL_HALF, XTAL_HALF);

    // R10: undefined bits have no effect
    wr(7'h00, 32'hE00F_FFFF | (32'd2 << 20));
    wr(7'h40, 32'hFFFF_FF72 | 32'h81 | (32'd3 << 2));
    expect_shape("R10 noisy bits div4", 8*PLL_HALF, 4*PLL_HALF);
    wr(7'h40, 32'hFFFF_FFF7);
    expect_shape("R10 noisy bits div2", 4*PLL_HALF, 2*PLL_HALF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == WATCHDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", wd, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule